// File: doc/BRIEF.md
# Sixteen-Bit Reload Timer with Hidden Reload Bytes

This block is a 16-bit up-counter reached through a byte-wide register port. The count is split into a low byte and a high byte. Each byte has a hidden reload byte behind the same address. The counter advances on one of three sources: every system clock, every twelfth system clock, or each falling edge of an external pin. A run bit gates all counting.

When the count passes its top value, the block raises an interrupt flag and reloads the count from the hidden bytes. The overflow period is therefore fixed by the reload value. Software loads the start value and the reload value together while the timer is stopped. While the timer runs, a write changes only the value used at the next reload. A read always returns the live count.

The flag stays set until software clears it. It can be cleared through the control register or with a dedicated strobe.

Top module: `reload_timer16`

## Requirements
- R1: After reset the live count, the reload bytes, the prescaler, the control bits and the interrupt flag are all zero: every read returns 0x00 and `irq` is low.
- R2: While the run bit is 0 the live count holds its value, whatever the source selection, the rate bit or `extPin` do.
- R3: With source bit 0 and rate bit 1, the count rises by one on every clock. A run started from reload value R first overflows 65536−R clocks after the start write, and again every 65536−R clocks.
- R4: With source bit 0 and rate bit 0, the count rises once per 12 clocks, so the overflow period is 12·(65536−R). The 12-clock prescaler restarts from zero whenever the run bit is 0.
- R5: With source bit 1, the count rises by exactly one per falling edge of `extPin`. The pin passes through two synchronizing flops first. The rate bit has no effect in this mode, and the count holds while the pin is idle.
- R6: While stopped, a write to address 0 sets the low byte of both the live count and its reload byte. A write to address 1 does the same for the high byte.
- R7: While running, a write to address 0 or 1 sets only the reload byte and leaves the live count unchanged.
- R8: Reads of address 0 and address 1 return the live count's low and high bytes, never the reload bytes.
- R9: When the count is 0xFFFF and a count step occurs, the live count becomes the 16-bit reload value and the interrupt flag is set.
- R10: The flag is cleared by `intClr` or by a write to address 2 with bit 3 at 0. Writing bit 3 as 1 leaves the flag as it was. An overflow in the same cycle as a clear leaves the flag set.
- R11: Address 2 is the control register: bit 0 run, bit 1 source (1 = external pin), bit 2 rate (1 = every clock), bit 3 the interrupt flag, upper bits read as 0. `irq` mirrors bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register address: 0 count low, 1 count high, 2 control |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data for the addressed register (combinational) |
| extPin | input | 1 | External pulse input for counting mode |
| intClr | input | 1 | Clears the interrupt flag |
| irq | output | 1 | Interrupt flag |

## Verification
The bench sweeps several reload values in both clock-rate modes and measures the cycles to the first overflow and to the second. This catches a divider that is off by one and a reload that lands one step late. A design whose prescaler keeps its old phase across a stop would give a first period shorter than 12 steps after a restart.

In counting mode the bench writes a new reload byte while running and confirms that the live count did not move. It then confirms that the next overflow loads the new byte. A design that wrote through to the live count, or read back the reload byte, would show the written value at once.

The flag tests hold a clear against back-to-back overflows and expect the flag to stay set. They also write bit 3 as 1 and expect no change. A design where the clear wins, or where writing 1 counts as a clear, fails these tests.

// File: rtl/rtimer_pkg.sv
package rtimer_pkg;
  typedef struct packed {
    logic tick;      // advance the live count this cycle
    logic wrLo;      // bus write to the low byte address
    logic wrHi;      // bus write to the high byte address
    logic copyLive;  // bus writes also reach the live count
  } tmrStrobe_t;
endpackage

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import rtimer_pkg::*;
#(
  parameter int SLOW_DIV = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busAddr,
  input  logic       busWrEn,
  input  logic [7:0] busWrData,
  input  logic       extPin,
  input  logic       intClr,
  input  logic       ovf,
  output tmrStrobe_t stb,
  output logic       runBit,
  output logic       extSel,
  output logic       fastRate,
  output logic       flag
);
  localparam int PRE_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

  logic wrCtrl;
  logic syncA, syncB, syncPrev;
  logic extFall;
  logic slowTick;

  assign wrCtrl = busWrEn && (busAddr == 2'd2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runBit   <= 1'b0;
      extSel   <= 1'b0;
      fastRate <= 1'b0;
    end else if (wrCtrl) begin
      runBit   <= busWrData[0];
      extSel   <= busWrData[1];
      fastRate <= busWrData[2];
    end
  end

  // overflow has priority over any clear
  always_ff @(posedge clk) begin
    if (!rstN)                                   flag <= 1'b0;
    else if (ovf)                                flag <= 1'b1;
    else if (intClr || (wrCtrl && !busWrData[3])) flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA    <= 1'b0;
      syncB    <= 1'b0;
      syncPrev <= 1'b0;
    end else begin
      syncA    <= extPin;
      syncB    <= syncA;
      syncPrev <= syncB;
    end
  end
  assign extFall = syncPrev && !syncB;

  generate
    if (SLOW_DIV > 1) begin : g_pre
      logic [PRE_W-1:0] preCnt;
      always_ff @(posedge clk) begin
        if (!rstN || !runBit)                   preCnt <= '0;
        else if (preCnt == PRE_W'(SLOW_DIV-1))  preCnt <= '0;
        else                                    preCnt <= preCnt + 1'b1;
      end
      assign slowTick = runBit && (preCnt == PRE_W'(SLOW_DIV-1));
    end else begin : g_nopre
      assign slowTick = runBit;
    end
  endgenerate

  always_comb begin
    stb.wrLo     = busWrEn && (busAddr == 2'd0);
    stb.wrHi     = busWrEn && (busAddr == 2'd1);
    stb.copyLive = !runBit;
    if (!runBit)       stb.tick = 1'b0;
    else if (extSel)   stb.tick = extFall;
    else if (fastRate) stb.tick = 1'b1;
    else               stb.tick = slowTick;
  end
endmodule

// File: rtl/timer_dp.sv
module timer_dp
  import rtimer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  tmrStrobe_t          stb,
  input  logic [BYTE_W-1:0]   wrData,
  output logic [2*BYTE_W-1:0] count,
  output logic [2*BYTE_W-1:0] reload,
  output logic                ovf
);
  localparam int CNT_W = 2 * BYTE_W;

  logic [1:0][BYTE_W-1:0] reloadLanes;
  logic [1:0]             laneWr;
  logic [CNT_W-1:0]       nextCount;

  assign laneWr = {stb.wrHi, stb.wrLo};

  generate
    for (genvar b = 0; b < 2; b++) begin : g_lane
      always_ff @(posedge clk) begin
        if (!rstN)          reloadLanes[b] <= '0;
        else if (laneWr[b]) reloadLanes[b] <= wrData;
      end
    end
  endgenerate
  assign reload = reloadLanes;

  assign ovf = stb.tick && (count == '1);

  always_comb begin
    nextCount = count;
    if (stb.tick) begin
      nextCount = ovf ? reload : count + 1'b1;
    end else if (stb.copyLive) begin
      if (stb.wrLo) nextCount[BYTE_W-1:0]     = wrData;
      if (stb.wrHi) nextCount[CNT_W-1:BYTE_W] = wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else       count <= nextCount;
  end
endmodule

// File: rtl/reload_timer16.sv
module reload_timer16
  import rtimer_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int SLOW_DIV = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWrEn,
  input  logic [BYTE_W-1:0] busWrData,
  output logic [BYTE_W-1:0] busRdData,
  input  logic              extPin,
  input  logic              intClr,
  output logic              irq
);
  localparam int CNT_W = 2 * BYTE_W;

  tmrStrobe_t       stb;
  logic             runBit, extSel, fastRate, flag, ovf;
  logic [CNT_W-1:0] liveCount, reloadVal;

  timer_ctrl #(.SLOW_DIV(SLOW_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData[7:0]), .extPin(extPin), .intClr(intClr), .ovf(ovf),
    .stb(stb), .runBit(runBit), .extSel(extSel), .fastRate(fastRate), .flag(flag)
  );

  timer_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(busWrData),
    .count(liveCount), .reload(reloadVal), .ovf(ovf)
  );

  always_comb begin
    case (busAddr)
      2'd0:    busRdData = liveCount[BYTE_W-1:0];
      2'd1:    busRdData = liveCount[CNT_W-1:BYTE_W];
      2'd2:    busRdData = BYTE_W'({flag, fastRate, extSel, runBit});
      default: busRdData = '0;
    endcase
  end

  assign irq = flag;
endmodule

// File: rtl/reload_timer16_chk.sv
module reload_timer16_chk
  import rtimer_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [1:0]          busAddr,
  input logic                busWrEn,
  input logic                intClr,
  input logic                irq,
  input tmrStrobe_t          stb,
  input logic                runBit,
  input logic                extSel,
  input logic                fastRate,
  input logic [2*BYTE_W-1:0] count,
  input logic [2*BYTE_W-1:0] reload
);
  localparam int CNT_W = 2 * BYTE_W;

  // R2
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runBit && !busWrEn) |=> $stable(count));

  // R3
  fast_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runBit && !extSel && fastRate && count != '1)
      |=> count == CNT_W'($past(count) + 1'b1));

  // R7
  run_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (runBit && busWrEn && busAddr == 2'd0 && !stb.tick)
      |=> count[BYTE_W-1:0] == $past(count[BYTE_W-1:0]));

  // R9
  wrap_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.tick && count == '1) |=> (count == $past(reload)) && irq);

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intClr && !(stb.tick && count == '1)) |=> !irq);
endmodule

bind reload_timer16 reload_timer16_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .intClr(intClr), .irq(irq), .stb(stb), .runBit(runBit), .extSel(extSel),
  .fastRate(fastRate), .count(liveCount), .reload(reloadVal)
);

// File: tb/reload_timer16_test.sv
`timescale 1ns/1ps
module reload_timer16_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = 8'h00;
  logic [7:0] busRdData;
  logic       extPin = 1'b0;
  logic       intClr = 1'b0;
  logic       irq;
  int vectors = 0;
  int fails = 0;

  always #10 clk = ~clk;

  reload_timer16 uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .extPin(extPin),
    .intClr(intClr), .irq(irq)
  );

  task automatic chk(string req, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; #1;
    d = busRdData;
  endtask

  task automatic peek16(output logic [15:0] v);
    busAddr = 2'd0; #1; v[7:0] = busRdData;
    busAddr = 2'd1; #1; v[15:8] = busRdData;
  endtask

  // counts rising edges until irq is seen at a falling edge
  task automatic measure(output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!irq && n < 5000);
  endtask

  task automatic extPulse();
    @(negedge clk); extPin = 1'b1;
    repeat (3) @(negedge clk);
    extPin = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic runPeriod(logic [15:0] r, bit fast, string req);
    logic [7:0] b;
    logic [15:0] v;
    int n;
    int exp;
    exp = (65536 - int'(r)) * (fast ? 1 : 12);
    wr(2'd2, 8'h00);
    wr(2'd0, r[7:0]);
    wr(2'd1, r[15:8]);
    rd(2'd0, b); chk("R6 stopped write low", b, r[7:0]);
    rd(2'd1, b); chk("R6 stopped write high", b, r[15:8]);
    wr(2'd2, fast ? 8'h05 : 8'h01);
    measure(n);
    chk(req, n, exp);
    peek16(v);
    chk("R9 count after wrap", v, r);
    if (exp > 2) begin
      intClr = 1'b1;
      @(posedge clk); #1;
      intClr = 1'b0;
      n = 1;
      forever begin
        @(negedge clk);
        if (irq || n > 5000) break;
        @(posedge clk); n++;
      end
      chk({req, " second period"}, n, exp);
    end
    wr(2'd2, 8'h00);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [15:0] v;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(2'd0, b); chk("R1 low byte", b, 0);
    rd(2'd1, b); chk("R1 high byte", b, 0);
    rd(2'd2, b); chk("R1 control", b, 0);
    chk("R1 irq", irq, 0);

    // R3 fast sweep
    runPeriod(16'hFFFF, 1'b1, "R3 period");
    runPeriod(16'hFFFE, 1'b1, "R3 period");
    runPeriod(16'hFFF0, 1'b1, "R3 period");
    runPeriod(16'hFF00, 1'b1, "R3 period");
    // R4 slow sweep
    runPeriod(16'hFFFF, 1'b0, "R4 period");
    runPeriod(16'hFFF8, 1'b0, "R4 period");
    runPeriod(16'hFFF1, 1'b0, "R4 period");

    // R2 stopped count holds
    wr(2'd2, 8'h04);
    wr(2'd0, 8'h34);
    wr(2'd1, 8'h12);
    repeat (20) @(negedge clk);
    peek16(v); chk("R2 hold while stopped", v, 16'h1234);

    // R4 prescaler restarts after stop
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h01);
    repeat (5) @(posedge clk);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h01);
    measure(n); chk("R4 restart phase", n, 12);
    wr(2'd2, 8'h00);

    // R5, R7, R8 counting mode
    wr(2'd2, 8'h02);
    wr(2'd0, 8'hFD);
    wr(2'd1, 8'hFF);
    extPulse();
    peek16(v); chk("R2 ext edge while stopped", v, 16'hFFFD);
    wr(2'd2, 8'h07);
    rd(2'd2, b); chk("R11 control readback", b, 8'h07);
    wr(2'd0, 8'h55);
    rd(2'd0, b); chk("R7 R8 live low kept", b, 8'hFD);
    repeat (30) @(negedge clk);
    peek16(v); chk("R5 idle pin holds", v, 16'hFFFD);
    extPulse();
    extPulse();
    peek16(v); chk("R5 one per edge", v, 16'hFFFF);
    chk("R5 no early flag", irq, 0);
    extPulse();
    peek16(v); chk("R9 reload uses new byte", v, 16'hFF55);
    chk("R9 flag set", irq, 1);
    rd(2'd2, b); chk("R11 flag bit", b, 8'h0F);

    // R10 flag write semantics
    wr(2'd2, 8'h0A);
    chk("R10 write one keeps flag", irq, 1);
    rd(2'd2, b); chk("R11 stopped readback", b, 8'h0A);
    wr(2'd2, 8'h02);
    chk("R10 write zero clears", irq, 0);

    // R10 overflow beats clear
    wr(2'd2, 8'h00);
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFF);
    wr(2'd2, 8'h05);
    @(negedge clk);
    intClr = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R10 overflow wins", irq, 1);
    end
    intClr = 1'b0;
    wr(2'd2, 8'h08);
    chk("R10 stop keeps flag", irq, 1);
    @(negedge clk); intClr = 1'b1;
    @(posedge clk); #1; intClr = 1'b0;
    @(negedge clk);
    chk("R10 strobe clears", irq, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule